// File: doc/BRIEF.md
# Logical Instruction Execute Unit

This unit carries out the bitwise logical subset of a 32-bit load/store style instruction set against its own register file of 32 registers. Each clock cycle it can take one 32-bit instruction word, marked by a valid strobe. It recognises four register-to-register forms (AND, OR, XOR, NOR) and three register-with-immediate forms (AND, OR, XOR with a 16-bit constant). It reads the two source registers and forms the result combinationally. The result is written back on the next rising clock edge.

Any word outside this subset raises an illegal flag for that cycle and writes nothing. The result and its destination index also appear on output ports in the same cycle as the instruction, so a surrounding pipeline or a bench can observe every operation. A separate debug port reads any register at any time without affecting execution.

Top module: `lgx_exec_unit`

## Requirements
- R1: With primary opcode 000000 and a zero shift amount, the function field selects the operation: 0x24 gives AND, 0x25 gives OR, 0x26 gives XOR and 0x27 gives NOR of registers rs and rt. The result goes to register rd.
- R2: Opcode 0x0C (AND), 0x0D (OR) and 0x0E (XOR) combine register rs with the 16-bit immediate, which is zero-extended so that its upper 16 bits are 0. The result goes to register rt.
- R3: The instruction fields sit at fixed bit positions: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift amount [10:6], function [5:0] and immediate [15:0]. Register indices are 5-bit unsigned numbers.
- R4: Register 0 always reads as zero, both as an operand and on the debug port. A legal instruction that targets register 0 leaves it zero.
- R5: A valid, legal instruction writes its result on the rising clock edge of the cycle in which it is presented. The debug port shows the new value from the following cycle on.
- R6: With the strobe high, `illegal` is 1 for three cases: an opcode other than 0x00, 0x0C, 0x0D or 0x0E; a function code under opcode 0x00 other than 0x24 to 0x27; or a nonzero shift amount in a register form. In all of these cases no register changes.
- R7: While `instr_valid` is 0, no register changes, and both `illegal` and `res_valid` are 0.
- R8: When `rst` is high at a rising clock edge, all registers are cleared to zero.
- R9: In the same cycle as a valid, legal instruction, `res_valid` is 1, `res_data` carries the result and `res_dest` carries the destination index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears the register file |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction to execute |
| dbg_addr | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Contents of register `dbg_addr` |
| res_valid | output | 1 | A legal instruction executes this cycle |
| res_data | output | 32 | Result of the current instruction |
| res_dest | output | 5 | Destination register of the current instruction |
| illegal | output | 1 | The current valid word is outside the supported subset |

## Verification
`res_valid`, `illegal`, `res_data` and `res_dest` are combinational from the current instruction and register contents. The bench therefore drives each word on a falling edge and samples these outputs 2 ns later, before the rising edge that performs the write. The register write lands on that rising edge and is visible on `dbg_data` from the following cycle. For this reason, debug reads are made one or more falling edges later, with the strobe dropped 1 ns after the write edge. Sweeps cover every opcode, every function code and every nonzero shift amount, together with rotating register triples and immediates, and they compare against a register model kept in the bench.

// File: rtl/lgx_pkg.sv
package lgx_pkg;
   localparam int INSN_W = 32;
   localparam int IDX_W  = 5;
   localparam int IMM_W  = 16;

   localparam logic [5:0] OPC_REG  = 6'h00;
   localparam logic [5:0] OPC_ANDI = 6'h0C;
   localparam logic [5:0] OPC_ORI  = 6'h0D;
   localparam logic [5:0] OPC_XORI = 6'h0E;

   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_XOR = 6'h26;
   localparam logic [5:0] FN_NOR = 6'h27;

   typedef enum logic [1:0] {
      LOP_AND = 2'd0,
      LOP_OR  = 2'd1,
      LOP_XOR = 2'd2,
      LOP_NOR = 2'd3
   } lop_e;

   typedef struct packed {
      logic             legal;
      lop_e             op;
      logic             use_imm;
      logic [IDX_W-1:0] src_a;
      logic [IDX_W-1:0] src_b;
      logic [IDX_W-1:0] dst;
      logic [IMM_W-1:0] imm;
   } dec_t;
endpackage

// File: rtl/lgx_decode.sv
module lgx_decode
   import lgx_pkg::*;
(
   input  logic [INSN_W-1:0] insn,
   output dec_t              dec
);
   logic [5:0]       opc;
   logic [5:0]       fn;
   logic [4:0]       shamt;

   assign opc   = insn[31:26];
   assign fn    = insn[5:0];
   assign shamt = insn[10:6];

   always_comb begin
      dec.legal   = 1'b0;
      dec.op      = LOP_AND;
      dec.use_imm = 1'b0;
      dec.src_a   = insn[25:21];
      dec.src_b   = insn[20:16];
      dec.dst     = insn[15:11];
      dec.imm     = insn[15:0];
      unique case (opc)
         OPC_REG: begin
            if (shamt == 5'd0) begin
               unique case (fn)
                  FN_AND:  begin dec.legal = 1'b1; dec.op = LOP_AND; end
                  FN_OR:   begin dec.legal = 1'b1; dec.op = LOP_OR;  end
                  FN_XOR:  begin dec.legal = 1'b1; dec.op = LOP_XOR; end
                  FN_NOR:  begin dec.legal = 1'b1; dec.op = LOP_NOR; end
                  default: dec.legal = 1'b0;
               endcase
            end
         end
         OPC_ANDI: begin
            dec.legal = 1'b1; dec.op = LOP_AND; dec.use_imm = 1'b1; dec.dst = insn[20:16];
         end
         OPC_ORI: begin
            dec.legal = 1'b1; dec.op = LOP_OR;  dec.use_imm = 1'b1; dec.dst = insn[20:16];
         end
         OPC_XORI: begin
            dec.legal = 1'b1; dec.op = LOP_XOR; dec.use_imm = 1'b1; dec.dst = insn[20:16];
         end
         default: dec.legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/lgx_alu.sv
module lgx_alu
   import lgx_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit SHARED_OR  = 1'b1
)(
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic              use_imm,
   input  lop_e              op,
   output logic [DATA_W-1:0] result
);
   localparam int PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] rhs;

   assign rhs = use_imm ? {{PAD_W{1'b0}}, imm} : opnd_b;

   generate
      if (SHARED_OR) begin : g_shared
         logic [DATA_W-1:0] or_v;
         assign or_v = opnd_a | rhs;
         always_comb begin
            unique case (op)
               LOP_AND: result = opnd_a & rhs;
               LOP_OR:  result = or_v;
               LOP_XOR: result = opnd_a ^ rhs;
               default: result = ~or_v;
            endcase
         end
      end else begin : g_direct
         always_comb begin
            unique case (op)
               LOP_AND: result = opnd_a & rhs;
               LOP_OR:  result = opnd_a | rhs;
               LOP_XOR: result = opnd_a ^ rhs;
               default: result = ~(opnd_a | rhs);
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/lgx_regfile.sv
module lgx_regfile #(
   parameter int DATA_W    = 32,
   parameter int REG_CNT   = 32,
   parameter int RD_PORTS  = 3,
   parameter bit ZERO_HARD = 1'b1,
   localparam int IDX_W    = $clog2(REG_CNT)
)(
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             wr_en,
   input  logic [IDX_W-1:0]                 wr_addr,
   input  logic [DATA_W-1:0]                wr_data,
   input  logic [RD_PORTS-1:0][IDX_W-1:0]   rd_addr,
   output logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data
);
   logic [REG_CNT-1:0][DATA_W-1:0] mem;
   logic                           wr_take;

   assign wr_take = wr_en && (!ZERO_HARD || (wr_addr != '0));

   always_ff @(posedge clk) begin
      if (rst) begin
         mem <= '0;
      end else if (wr_take) begin
         mem[wr_addr] <= wr_data;
      end
   end

   generate
      for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
         if (ZERO_HARD) begin : g_z
            assign rd_data[p] = (rd_addr[p] == '0) ? '0 : mem[rd_addr[p]];
         end else begin : g_nz
            assign rd_data[p] = mem[rd_addr[p]];
         end
      end
   endgenerate

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr != '0) |=> (mem[$past(wr_addr)] == $past(wr_data))); // R5
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(mem)); // R7

   generate
      if (ZERO_HARD) begin : g_r0chk
         for (genvar q = 0; q < RD_PORTS; q++) begin : g_q
            AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
               (rd_addr[q] == '0) |-> (rd_data[q] == '0)); // R4
         end
      end
   endgenerate
endmodule

// File: rtl/lgx_exec_unit.sv
module lgx_exec_unit
   import lgx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int REG_CNT   = 32,
   parameter bit SHARED_OR = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              instr_valid,
   input  logic [31:0]       instr_word,
   input  logic [4:0]        dbg_addr,
   output logic [DATA_W-1:0] dbg_data,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic [4:0]        res_dest,
   output logic              illegal
);
   localparam int RD_PORTS = 3;

   generate
      if (REG_CNT != (1 << IDX_W)) begin : g_bad_cnt
         $error("REG_CNT must equal the span of a register index field");
      end
      if (DATA_W <= IMM_W) begin : g_bad_w
         $error("DATA_W must be wider than the immediate");
      end
   endgenerate

   dec_t                              dec;
   logic                              wr_en;
   logic [RD_PORTS-1:0][IDX_W-1:0]    rd_addr;
   logic [RD_PORTS-1:0][DATA_W-1:0]   rd_data;

   lgx_decode u_dec (
      .insn (instr_word),
      .dec  (dec)
   );

   assign rd_addr[0] = dec.src_a;
   assign rd_addr[1] = dec.src_b;
   assign rd_addr[2] = dbg_addr;

   lgx_regfile #(
      .DATA_W    (DATA_W),
      .REG_CNT   (REG_CNT),
      .RD_PORTS  (RD_PORTS),
      .ZERO_HARD (1'b1)
   ) u_rf (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (dec.dst),
      .wr_data (res_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   lgx_alu #(
      .DATA_W    (DATA_W),
      .SHARED_OR (SHARED_OR)
   ) u_alu (
      .opnd_a  (rd_data[0]),
      .opnd_b  (rd_data[1]),
      .imm     (dec.imm),
      .use_imm (dec.use_imm),
      .op      (dec.op),
      .result  (res_data)
   );

   assign res_valid = instr_valid && dec.legal;
   assign illegal   = instr_valid && !dec.legal;
   assign wr_en     = res_valid;
   assign res_dest  = dec.dst;
   assign dbg_data  = rd_data[2];

   AST_ILLEGAL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
      illegal |=> (dbg_data == $past(dbg_data) || dbg_addr != $past(dbg_addr))); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !instr_valid |-> (!illegal && !res_valid)); // R7
   AST_ANDI_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && instr_word[31:26] == OPC_ANDI) |-> (res_data[DATA_W-1:IMM_W] == '0)); // R2
   AST_IMM_DEST_RT: assert property (@(posedge clk) disable iff (rst)
      (res_valid && instr_word[31:26] != OPC_REG) |-> (res_dest == instr_word[20:16])); // R3
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
      $onehot0({res_valid, illegal})); // R9
endmodule

// File: tb/lgx_exec_unit_tb_top.sv
`timescale 1ns/1ps
module lgx_exec_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        instr_valid;
   logic [31:0] instr_word;
   logic [4:0]  dbg_addr;
   logic [31:0] dbg_data;
   logic        res_valid;
   logic [31:0] res_data;
   logic [4:0]  res_dest;
   logic        illegal;

   always #4 clk = ~clk;

   lgx_exec_unit dut_i (
      .clk (clk), .rst (rst), .instr_valid (instr_valid), .instr_word (instr_word),
      .dbg_addr (dbg_addr), .dbg_data (dbg_data), .res_valid (res_valid),
      .res_data (res_data), .res_dest (res_dest), .illegal (illegal)
   );

   logic [31:0] model [32];
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rform(input int rs, input int rt, input int rd,
                                         input int sh, input logic [5:0] fn);
      return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn};
   endfunction

   function automatic logic [31:0] iform(input logic [5:0] opc, input int rs, input int rt,
                                         input logic [15:0] imm);
      return {opc, rs[4:0], rt[4:0], imm};
   endfunction

   task automatic refop(input logic [31:0] w, output bit ok, output logic [4:0] d,
                        output logic [31:0] v);
      logic [31:0] a, b, zx;
      a  = model[w[25:21]];
      b  = model[w[20:16]];
      zx = {16'h0000, w[15:0]};
      ok = 1'b0; d = 5'd0; v = 32'd0;
      if (w[31:26] == 6'h00 && w[10:6] == 5'd0) begin
         d = w[15:11];
         case (w[5:0])
            6'h24: begin ok = 1'b1; v = a & b; end
            6'h25: begin ok = 1'b1; v = a | b; end
            6'h26: begin ok = 1'b1; v = a ^ b; end
            6'h27: begin ok = 1'b1; v = ~(a | b); end
            default: ok = 1'b0;
         endcase
      end else begin
         d = w[20:16];
         case (w[31:26])
            6'h0C: begin ok = 1'b1; v = a & zx; end
            6'h0D: begin ok = 1'b1; v = a | zx; end
            6'h0E: begin ok = 1'b1; v = a ^ zx; end
            default: ok = 1'b0;
         endcase
      end
   endtask

   task automatic issue(input string tag, input logic [31:0] w, input bit v);
      bit ok;
      logic [4:0] d;
      logic [31:0] val;
      @(negedge clk);
      instr_word  = w;
      instr_valid = v;
      #2;
      refop(w, ok, d, val);
      check({tag, " R9 res_valid"}, {31'b0, res_valid}, {31'b0, v && ok});
      check({tag, " R6 illegal"}, {31'b0, illegal}, {31'b0, v && !ok});
      if (v && ok) begin
         check({tag, " R9 res_data"}, res_data, val);
         check({tag, " R3 res_dest"}, {27'b0, res_dest}, {27'b0, d});
      end
      @(posedge clk);
      #1;
      if (v && ok && d != 5'd0) model[d] = val;
      instr_valid = 1'b0;
   endtask

   task automatic dbg_sweep(input string tag);
      for (int a = 0; a < 32; a++) begin
         @(negedge clk);
         dbg_addr = a[4:0];
         #1;
         check(tag, dbg_data, model[a]);
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [5:0] fns [4];
      logic [5:0] iops [3];
      fns[0] = 6'h24; fns[1] = 6'h25; fns[2] = 6'h26; fns[3] = 6'h27;
      iops[0] = 6'h0C; iops[1] = 6'h0D; iops[2] = 6'h0E;
      for (int i = 0; i < 32; i++) model[i] = 32'd0;
      rst = 1'b1; instr_valid = 1'b0; instr_word = 32'd0; dbg_addr = 5'd0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      dbg_sweep("R8 initial reset");

      // R2 load registers from r0 with zero-extended immediates
      for (int k = 1; k < 32; k++)
         issue("R2 ori load", iform(6'h0D, 0, k, 16'(k * 16'h1357) ^ 16'hA5C3), 1'b1);
      // R1 spread bits into upper halves with register forms
      for (int f = 0; f < 4; f++)
         for (int i = 0; i < 32; i++)
            issue("R1 reg form", rform(i, (i * 7 + 3) % 32, (i * 5 + 1) % 32, 0, fns[f]), 1'b1);
      dbg_sweep("R5 writeback after R1");
      // R2 immediate forms with upper data set
      for (int o = 0; o < 3; o++)
         for (int i = 0; i < 32; i++)
            issue("R2 imm form", iform(iops[o], (i * 3 + 2) % 32, (i * 11 + 5) % 32,
                  16'(i * 16'h9E37)), 1'b1);
      dbg_sweep("R5 writeback after R2");

      // R4 register zero
      issue("R4 ori to r0", iform(6'h0D, 7, 0, 16'hFFFF), 1'b1);
      issue("R4 nor to r0", rform(3, 4, 0, 0, 6'h27), 1'b1);
      issue("R4 r0 as source", rform(0, 0, 9, 0, 6'h27), 1'b1);
      @(negedge clk); dbg_addr = 5'd0; #1;
      check("R4 r0 debug read", dbg_data, 32'd0);

      // R6 every opcode, every function code, every nonzero shift amount
      for (int o = 0; o < 64; o++)
         issue("R6 opcode sweep", {o[5:0], 5'd3, 5'd4, 16'h2824}, 1'b1);
      for (int f = 0; f < 64; f++)
         issue("R6 funct sweep", rform(1, 2, 7, 0, f[5:0]), 1'b1);
      for (int s = 1; s < 32; s++)
         issue("R6 shamt sweep", rform(5, 6, 8, s, 6'h25), 1'b1);
      dbg_sweep("R6 registers after illegal words");

      // R7 strobe low
      issue("R7 idle ori", iform(6'h0D, 0, 12, 16'h1234), 1'b0);
      issue("R7 idle and", rform(1, 2, 13, 0, 6'h24), 1'b0);
      issue("R7 idle illegal", 32'hFFFF_FFFF, 1'b0);
      dbg_sweep("R7 registers after idle cycles");

      // R8 reset clears loaded registers
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1 rst = 1'b0;
      for (int i = 0; i < 32; i++) model[i] = 32'd0;
      dbg_sweep("R8 reset clears");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule